// File: doc/BRIEF.md
# Programmable Countdown Event Timer Bank

This block holds a small bank of independent countdown timers behind one register window. Each timer counts down once per strobe of an externally generated microsecond tick. Software starts a timer with a single write that carries an enable flag, a repeat flag and a starting count. When a running timer has reached zero and one more tick arrives, it raises its level-high interrupt line.

With the repeat flag clear, the timer then switches itself off. With the repeat flag set, it reloads its starting count and keeps running. A software request to wait N ticks is written as N − 1, so a written count of 0 fires on the first tick. A separate status register of each timer reports the remaining count and the pending flag. Writing a one to the pending-flag position of that register acknowledges the interrupt.

Channel bases in the window are 0x00, 0x08, 0x50 and 0x58. Each channel has a control word at base + 0 and a status word at base + 4.

Top module: `evt_timer_bank`

## Requirements
- R1: After reset every interrupt line is low, and all eight channel registers read as zero.
- R2: In the control word, bit 31 is the enable flag, bit 30 is the repeat flag and bits 28:0 are the start count. Bit 29 is ignored. Reading the control word returns the stored flags and start count, with the enable flag as it currently stands.
- R3: Channel i has its control word at base + 0x0 and its status word at base + 0x4, with bases 0x00, 0x08, 0x50 and 0x58 for i = 0..3. Writes to any other address change nothing, and reads from any other address return zero.
- R4: An enabled timer changes its count only in a cycle that carries a tick. With start count N − 1 the interrupt rises after exactly the N-th tick.
- R5: In one-shot mode (repeat flag 0), expiry clears the enable flag and leaves the count at 0, so later ticks raise no new interrupt.
- R6: In repeat mode (repeat flag 1), expiry reloads the start count and keeps the timer enabled, and it expires again after another N ticks.
- R7: Writing zero to the control word stops the timer. Its count reads 0 and ticks then have no effect.
- R8: The status word returns the remaining count in bits 28:0 and the pending flag in bit 30. All other bits read as zero.
- R9: A status write with bit 30 set clears the pending flag. A status write with bit 30 clear leaves it unchanged.
- R10: When an expiry and a status clear fall in the same cycle, the pending flag stays set.
- R11: Writing or reading one channel leaves the count and the flags of every other channel unchanged.
- R12: The interrupt line is the pending flag itself, a level that stays high until software clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle strobe per microsecond, shared by all channels |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 8 | Byte address in the timer window |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| irq_o | output | 4 | Level-high interrupt, one bit per channel |

## Verification
The bench programs each channel and walks it up to the edge of expiry. It checks that the interrupt appears on exactly the N-th tick: a counter that fires when it reaches zero rather than one tick later would be one tick early. Same-cycle collisions get directed tests. An acknowledge that lands on an expiry must not lose the new event, and a write to an unmapped address or a status write without bit 30 must change nothing. Repeat and one-shot runs confirm reload against stop. A design that reloaded in one-shot mode would raise a second interrupt, and one that stopped in repeat mode would never fire again.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

   localparam int REG_W    = 32;
   localparam int EN_POS   = 31;
   localparam int RPT_POS  = 30;
   localparam int PEND_POS = 30;
   localparam int CTRL_OFS = 0;
   localparam int STAT_OFS = 4;
   localparam int MAX_CH   = 4;
   localparam int MAX_CNT_W = 29;

   // Channel base: odd channels sit 8 bytes above even ones, upper pair at 0x50
   function automatic int chan_base(input int idx);
      return (idx / 2) * 'h50 + (idx % 2) * 'h08;
   endfunction

endpackage

// File: rtl/evt_timer_chan.sv
module evt_timer_chan
   import evt_timer_pkg::*;
#(
   parameter int CNT_W = 29
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             tick_i,
   input  logic             load_i,
   input  logic             load_en_i,
   input  logic             load_rpt_i,
   input  logic [CNT_W-1:0] load_cnt_i,
   input  logic             clr_i,
   output logic [REG_W-1:0] ctrl_rd_o,
   output logic [REG_W-1:0] stat_rd_o,
   output logic             irq_o
);

   if (CNT_W < 1 || CNT_W > MAX_CNT_W) begin : g_bad_cnt_w
      $error("evt_timer_chan: CNT_W out of range");
   end

   logic             en_q;
   logic             rpt_q;
   logic [CNT_W-1:0] start_q;
   logic [CNT_W-1:0] cnt_q;
   logic             pend_q;
   logic             at_zero;
   logic             expire;

   assign at_zero = (cnt_q == '0);
   assign expire  = tick_i & en_q & at_zero & ~load_i;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         en_q    <= 1'b0;
         rpt_q   <= 1'b0;
         start_q <= '0;
         cnt_q   <= '0;
      end else if (load_i) begin
         en_q    <= load_en_i;
         rpt_q   <= load_rpt_i;
         start_q <= load_cnt_i;
         cnt_q   <= load_cnt_i;
      end else if (tick_i && en_q) begin
         if (at_zero) begin
            if (rpt_q) cnt_q <= start_q;
            else       en_q  <= 1'b0;
         end else begin
            cnt_q <= cnt_q - CNT_W'(1);
         end
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni)     pend_q <= 1'b0;
      else if (expire) pend_q <= 1'b1;
      else if (clr_i)  pend_q <= 1'b0;
   end

   always_comb begin
      ctrl_rd_o              = '0;
      ctrl_rd_o[EN_POS]      = en_q;
      ctrl_rd_o[RPT_POS]     = rpt_q;
      ctrl_rd_o[CNT_W-1:0]   = start_q;
      stat_rd_o              = '0;
      stat_rd_o[PEND_POS]    = pend_q;
      stat_rd_o[CNT_W-1:0]   = cnt_q;
   end

   assign irq_o = pend_q;

   AST_TICK_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!tick_i && !load_i) |=> ($stable(cnt_q) && $stable(en_q))); // R4
   AST_STEP_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_i && en_q && cnt_q != '0 && !load_i) |=> (cnt_q == $past(cnt_q) - CNT_W'(1))); // R4
   AST_ONESHOT_HALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_i && en_q && !rpt_q && cnt_q == '0 && !load_i) |=> (!en_q && irq_o && cnt_q == '0)); // R5
   AST_REPEAT_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_i && en_q && rpt_q && cnt_q == '0 && !load_i) |=> (en_q && irq_o && cnt_q == start_q)); // R6
   AST_IRQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_o && !clr_i) |=> irq_o); // R12
   AST_EXPIRY_BEATS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i && tick_i && en_q && cnt_q == '0 && !load_i) |=> irq_o); // R10

endmodule

// File: rtl/evt_timer_decode.sv
module evt_timer_decode
   import evt_timer_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int ADDR_W = 8
) (
   input  logic                         clk_i,
   input  logic                         rst_ni,
   input  logic                         bus_we_i,
   input  logic [ADDR_W-1:0]            bus_addr_i,
   input  logic [NUM_CH-1:0][REG_W-1:0] ctrl_rd_i,
   input  logic [NUM_CH-1:0][REG_W-1:0] stat_rd_i,
   output logic [NUM_CH-1:0]            ctrl_we_o,
   output logic [NUM_CH-1:0]            stat_we_o,
   output logic [REG_W-1:0]             bus_rdata_o
);

   if (NUM_CH < 1 || NUM_CH > MAX_CH) begin : g_bad_num_ch
      $error("evt_timer_decode: NUM_CH out of range");
   end
   if (ADDR_W < 7) begin : g_bad_addr_w
      $error("evt_timer_decode: ADDR_W too small for channel bases");
   end

   logic [NUM_CH-1:0] ctrl_hit;
   logic [NUM_CH-1:0] stat_hit;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_hit
      localparam logic [ADDR_W-1:0] CtrlAddr = ADDR_W'(chan_base(i) + CTRL_OFS);
      localparam logic [ADDR_W-1:0] StatAddr = ADDR_W'(chan_base(i) + STAT_OFS);
      assign ctrl_hit[i]  = (bus_addr_i == CtrlAddr);
      assign stat_hit[i]  = (bus_addr_i == StatAddr);
      assign ctrl_we_o[i] = bus_we_i & ctrl_hit[i];
      assign stat_we_o[i] = bus_we_i & stat_hit[i];
   end

   always_comb begin
      bus_rdata_o = '0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (ctrl_hit[i]) bus_rdata_o = ctrl_rd_i[i];
         if (stat_hit[i]) bus_rdata_o = stat_rd_i[i];
      end
   end

   AST_SINGLE_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({ctrl_we_o, stat_we_o})); // R3
   AST_WRITE_NEEDS_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !bus_we_i |-> ({ctrl_we_o, stat_we_o} == '0)); // R3

endmodule

// File: rtl/evt_timer_bank.sv
module evt_timer_bank
   import evt_timer_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int CNT_W  = 29,
   parameter int ADDR_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              tick_i,
   input  logic              bus_we_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic [REG_W-1:0]  bus_wdata_i,
   output logic [REG_W-1:0]  bus_rdata_o,
   output logic [NUM_CH-1:0] irq_o
);

   if (CNT_W < 1 || CNT_W > MAX_CNT_W) begin : g_bad_cnt_w
      $error("evt_timer_bank: CNT_W out of range");
   end

   logic [NUM_CH-1:0][REG_W-1:0] ctrl_rd;
   logic [NUM_CH-1:0][REG_W-1:0] stat_rd;
   logic [NUM_CH-1:0]            ctrl_we;
   logic [NUM_CH-1:0]            stat_we;
   logic                         unused_wbits;

   assign unused_wbits = ^bus_wdata_i[MAX_CNT_W:CNT_W];

   evt_timer_decode #(
      .NUM_CH (NUM_CH),
      .ADDR_W (ADDR_W)
   ) u_decode (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .bus_we_i    (bus_we_i),
      .bus_addr_i  (bus_addr_i),
      .ctrl_rd_i   (ctrl_rd),
      .stat_rd_i   (stat_rd),
      .ctrl_we_o   (ctrl_we),
      .stat_we_o   (stat_we),
      .bus_rdata_o (bus_rdata_o)
   );

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      evt_timer_chan #(
         .CNT_W (CNT_W)
      ) u_chan (
         .clk_i      (clk_i),
         .rst_ni     (rst_ni),
         .tick_i     (tick_i),
         .load_i     (ctrl_we[i]),
         .load_en_i  (bus_wdata_i[EN_POS]),
         .load_rpt_i (bus_wdata_i[RPT_POS]),
         .load_cnt_i (bus_wdata_i[CNT_W-1:0]),
         .clr_i      (stat_we[i] & bus_wdata_i[PEND_POS]),
         .ctrl_rd_o  (ctrl_rd[i]),
         .stat_rd_o  (stat_rd[i]),
         .irq_o      (irq_o[i])
      );
   end

   AST_RESET_QUIET: assert property (@(posedge clk_i)
      !rst_ni |=> (irq_o == '0)); // R1

endmodule

// File: tb/evt_timer_bank_bench.sv
module evt_timer_bank_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        we = 1'b0;
   logic [7:0]  addr = 8'h00;
   logic [31:0] wdata = 32'h0;
   logic [31:0] rdata;
   logic [3:0]  irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   evt_timer_bank u_evt_timer_bank (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .tick_i      (tick),
      .bus_we_i    (we),
      .bus_addr_i  (addr),
      .bus_wdata_i (wdata),
      .bus_rdata_o (rdata),
      .irq_o       (irq)
   );

   // Vector table: channel, control word, ticks, expected status, control readback, irq
   localparam int NV = 6;
   localparam int          V_CH    [NV] = '{0, 1, 2, 3, 0, 1};
   localparam logic [31:0] V_CTRL  [NV] = '{32'h8000_0009, 32'h8000_0004, 32'hC000_0002,
                                            32'hC000_0002, 32'h8000_0000, 32'hBFFF_FFFF};
   localparam int          V_TICKS [NV] = '{4, 5, 3, 4, 1, 3};
   localparam logic [31:0] V_STAT  [NV] = '{32'h0000_0005, 32'h4000_0000, 32'h4000_0002,
                                            32'h4000_0001, 32'h4000_0000, 32'h1FFF_FFFC};
   localparam logic [31:0] V_CRB   [NV] = '{32'h8000_0009, 32'h0000_0004, 32'hC000_0002,
                                            32'hC000_0002, 32'h0000_0000, 32'h9FFF_FFFF};
   localparam logic        V_IRQ   [NV] = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0};

   function automatic logic [7:0] base_of(input int ch);
      case (ch)
         0:       return 8'h00;
         1:       return 8'h08;
         2:       return 8'h50;
         default: return 8'h58;
      endcase
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      we = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      we = 1'b0; wdata = 32'h0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      addr = a;
      #1 d = rdata;
   endtask

   task automatic ticks(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk); tick = 1'b1;
         @(negedge clk); tick = 1'b0;
      end
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic quiesce();
      for (int c = 0; c < 4; c++) begin
         wr(base_of(c), 32'h0);
         wr(base_of(c) + 8'h4, 32'h4000_0000);
      end
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL R4 watchdog: actual=running expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      idle(4);
      rst_n = 1'b1;
      idle(1);

      // R1: reset state
      chk("R1 irq after reset", {28'h0, irq}, 32'h0);
      for (int c = 0; c < 4; c++) begin
         rd(base_of(c), d);        chk("R1 ctrl after reset", d, 32'h0);
         rd(base_of(c) + 8'h4, d); chk("R1 stat after reset", d, 32'h0);
      end

      // Table walk: R2 control layout, R8 status layout, R4/R5/R6 counting
      for (int v = 0; v < NV; v++) begin
         quiesce();
         wr(base_of(V_CH[v]), V_CTRL[v]);
         ticks(V_TICKS[v]);
         rd(base_of(V_CH[v]) + 8'h4, d); chk("R8 status after ticks", d, V_STAT[v]);
         rd(base_of(V_CH[v]), d);        chk("R2 control readback", d, V_CRB[v]);
         chk("R4 irq after ticks", {31'h0, irq[V_CH[v]]}, {31'h0, V_IRQ[v]});
      end

      // R4: exactly N ticks for start count N-1
      quiesce();
      wr(8'h00, 32'h8000_0002);
      ticks(2);
      chk("R4 no irq before N-th tick", {31'h0, irq[0]}, 32'h0);
      ticks(1);
      chk("R4 irq on N-th tick", {31'h0, irq[0]}, 32'h1);

      // R12 level hold, R9 clear rules
      idle(4);
      chk("R12 irq held without clear", {31'h0, irq[0]}, 32'h1);
      wr(8'h04, 32'h0);
      chk("R9 clear without bit 30 ignored", {31'h0, irq[0]}, 32'h1);
      wr(8'h04, 32'h4000_0000);
      chk("R9 clear with bit 30", {31'h0, irq[0]}, 32'h0);

      // R5: one-shot stays stopped
      ticks(10);
      chk("R5 no second irq", {31'h0, irq[0]}, 32'h0);
      rd(8'h04, d); chk("R5 count stays zero", d, 32'h0);
      rd(8'h00, d); chk("R5 enable cleared", d, 32'h0000_0002);

      // R6: repeat mode fires again
      quiesce();
      wr(8'h50, 32'hC000_0001);
      ticks(2);
      chk("R6 first expiry", {31'h0, irq[2]}, 32'h1);
      wr(8'h54, 32'h4000_0000);
      ticks(1);
      chk("R6 no irq mid period", {31'h0, irq[2]}, 32'h0);
      ticks(1);
      chk("R6 second expiry", {31'h0, irq[2]}, 32'h1);

      // R7: writing zero stops
      quiesce();
      wr(8'h08, 32'h8000_0005);
      ticks(2);
      rd(8'h0C, d); chk("R7 running count", d, 32'h0000_0003);
      wr(8'h08, 32'h0);
      ticks(10);
      chk("R7 stopped no irq", {31'h0, irq[1]}, 32'h0);
      rd(8'h0C, d); chk("R7 stopped count", d, 32'h0);

      // R4 no tick no change, R11 independence
      quiesce();
      wr(8'h58, 32'h8000_0007);
      idle(5);
      rd(8'h5C, d); chk("R4 count holds without tick", d, 32'h0000_0007);
      wr(8'h00, 32'h8000_0003);
      wr(8'h0C, 32'h4000_0000);
      rd(8'h5C, d); chk("R11 other channel status untouched", d, 32'h0000_0007);
      rd(8'h58, d); chk("R11 other channel control untouched", d, 32'h8000_0007);

      // R10: clear and expiry in one cycle
      quiesce();
      wr(8'h58, 32'hC000_0000);
      ticks(1);
      chk("R10 pend set", {31'h0, irq[3]}, 32'h1);
      @(negedge clk);
      tick = 1'b1; we = 1'b1; addr = 8'h5C; wdata = 32'h4000_0000;
      @(negedge clk);
      tick = 1'b0; we = 1'b0; wdata = 32'h0;
      chk("R10 expiry wins over clear", {31'h0, irq[3]}, 32'h1);
      wr(8'h5C, 32'h4000_0000);
      chk("R10 clear alone works", {31'h0, irq[3]}, 32'h0);

      // R3: unmapped addresses
      quiesce();
      wr(8'h20, 32'hFFFF_FFFF);
      wr(8'h5C + 8'h4, 32'hFFFF_FFFF);
      rd(8'h20, d); chk("R3 unmapped read zero", d, 32'h0);
      rd(8'h60, d); chk("R3 unmapped read zero", d, 32'h0);
      for (int c = 0; c < 4; c++) begin
         rd(base_of(c), d);        chk("R3 control untouched", d, 32'h0);
         rd(base_of(c) + 8'h4, d); chk("R3 status untouched", d, 32'h0);
      end
      ticks(3);
      chk("R3 no irq from stray write", {28'h0, irq}, 32'h0);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule